// File: doc/BRIEF.md
# Odd/Even Audio Clock Prescaler

This block derives the bit-rate clock of a serial audio interface from a faster source clock. The division ratio is set by an 8-bit divider field and a one-bit odd flag. The ratio equals twice the divider field, plus one when the odd flag is set. The block drives a divided clock, a one-cycle tick that marks each rising edge of that clock, and a master-clock output that an enable bit can hold inactive.

Configuration is written through a write strobe. The divider, odd flag, master-clock enable, channel length and data length are accepted only while the audio interface is disabled; any write made while it is enabled is dropped. The block raises a configuration-error flag for two cases: a zero divider, or a data length that does not fit the channel length. While that flag is raised the divided clock stays low.

Top module: `audio_clk_prescaler`

## Requirements
- R1: With the odd flag at 0, the divided clock has a period of exactly 2 × divider source cycles, high for the first half and low for the second.
- R2: With the odd flag at 1, the period is 2 × divider + 1 source cycles, and the high phase is one cycle longer than the low phase.
- R3: After reset the divider is 2, the odd flag is 0, the master-clock enable is 0, the channel length is 16 bits and the data length is 16 bits. The ratio is therefore 4, all outputs are low and the error flag is clear.
- R4: A divider of 0 raises the error flag, and the divided clock, tick and master clock stay low even with the interface enabled.
- R5: The channel length code `cfg_chan32` is 0 for 16 bits and 1 for 32 bits. The data length code `cfg_dlen` is 00 for 16 bits, 01 for 24 bits, 10 for 32 bits, and 11 is reserved. The error flag is raised when the data is longer than the channel or the code is reserved.
- R6: When the master-clock enable is 1, `mclk_out` equals the divided clock in every cycle. When the enable is 0, `mclk_out` is held low.
- R7: A configuration write made while `if_en` is 1 has no effect. The divider, odd flag and enables keep their earlier values.
- R8: While `if_en` is 0 the divided clock and tick are low. The first clock edge that samples `if_en` at 1 with a valid configuration drives the divided clock high and starts a fresh period.
- R9: `tick` is high for exactly one cycle, in the cycle where the divided clock goes from low to high, and at no other time.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_en | input | 1 | Audio interface enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_div | input | 8 | Divider field to write |
| cfg_odd | input | 1 | Odd flag to write |
| cfg_mck_en | input | 1 | Master-clock output enable to write |
| cfg_chan32 | input | 1 | Channel length code to write (0 = 16 bits, 1 = 32 bits) |
| cfg_dlen | input | 2 | Data length code to write |
| div_clk | output | 1 | Divided clock |
| tick | output | 1 | One-cycle pulse on each rising edge of div_clk |
| mclk_out | output | 1 | Gated master-clock output |
| cfg_err | output | 1 | Invalid configuration flag |

## Verification
A configuration write takes effect at the clock edge that samples the strobe. The error flag is derived combinationally from the stored settings, so it is checked one cycle after the write. All three clock outputs are registered, so the result for the first period appears at the edge that first samples `if_en` high, and the outputs fall at the edge that first samples it low. The driver pushes one expected triple per clock edge into a queue when it raises `if_en`. The monitor pops one triple shortly after each rising edge, which keeps every comparison aligned to the cycle in which the registers change.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int DIV_W = 8;
  localparam int RAT_W = DIV_W + 1;

  typedef enum logic [1:0] {
    DLEN_16  = 2'b00,
    DLEN_24  = 2'b01,
    DLEN_32  = 2'b10,
    DLEN_RSV = 2'b11
  } dlen_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mck_en;
    logic             chan32;
    dlen_e            dlen;
  } aclk_cfg_t;

  // full period in source cycles
  function automatic logic [RAT_W-1:0] ratio_of(logic [DIV_W-1:0] d, logic o);
    return {d, 1'b0} + RAT_W'(o);
  endfunction

  // high phase takes the extra cycle of an odd ratio
  function automatic logic [RAT_W-1:0] high_len(logic [RAT_W-1:0] r);
    return r - (r >> 1);
  endfunction

  function automatic logic pairing_ok(logic chan32, dlen_e dl);
    case (dl)
      DLEN_16: return 1'b1;
      DLEN_24: return chan32;
      DLEN_32: return chan32;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/aclk_cfg_regs.sv
module aclk_cfg_regs
  import aclk_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 8'd2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      if_en,
  input  logic      we,
  input  aclk_cfg_t wdata,
  output aclk_cfg_t cfg_q,
  output logic      wr_take
);

  assign wr_take = we & ~if_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.div    <= RESET_DIV;
      cfg_q.odd    <= 1'b0;
      cfg_q.mck_en <= 1'b0;
      cfg_q.chan32 <= 1'b0;
      cfg_q.dlen   <= DLEN_16;
    end else if (wr_take) begin
      cfg_q <= wdata;
    end
  end

endmodule

// File: rtl/aclk_cfg_check.sv
module aclk_cfg_check
  import aclk_pkg::*;
(
  input  aclk_cfg_t cfg,
  output logic      div_zero,
  output logic      len_bad,
  output logic      err
);

  assign div_zero = (cfg.div == '0);
  assign len_bad  = ~pairing_ok(cfg.chan32, cfg.dlen);
  assign err      = div_zero | len_bad;

endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
  import aclk_pkg::*;
#(
  parameter int W = RAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] ratio,
  input  logic         mck_en,
  output logic         div_clk,
  output logic         tick,
  output logic         mclk_out,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nx;
  logic [W-1:0] hi_len;
  logic         out_nx;

  // parked at all ones while idle so the first running edge lands on 0
  assign wrap   = (cnt_q >= ratio - W'(1));
  assign cnt_nx = wrap ? '0 : cnt_q + W'(1);
  assign hi_len = high_len(ratio);
  assign out_nx = run & (cnt_nx < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '1;
      div_clk  <= 1'b0;
      tick     <= 1'b0;
      mclk_out <= 1'b0;
    end else begin
      cnt_q    <= run ? cnt_nx : '1;
      div_clk  <= out_nx;
      tick     <= run & wrap;
      mclk_out <= out_nx & mck_en;
    end
  end

endmodule

// File: rtl/audio_clk_prescaler.sv
module audio_clk_prescaler
  import aclk_pkg::*;
#(
  parameter logic [DIV_W-1:0] RESET_DIV = 8'd2
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             if_en,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_odd,
  input  logic             cfg_mck_en,
  input  logic             cfg_chan32,
  input  logic [1:0]       cfg_dlen,
  output logic             div_clk,
  output logic             tick,
  output logic             mclk_out,
  output logic             cfg_err
);

  aclk_cfg_t        wdata;
  aclk_cfg_t        cfg_q;
  logic             wr_take;
  logic             div_zero;
  logic             len_bad;
  logic             run;
  logic             wrap;
  logic [RAT_W-1:0] ratio;
  logic [DIV_W-1:0] div_q;
  logic             mck_en_q;

  assign wdata.div    = cfg_div;
  assign wdata.odd    = cfg_odd;
  assign wdata.mck_en = cfg_mck_en;
  assign wdata.chan32 = cfg_chan32;
  assign wdata.dlen   = dlen_e'(cfg_dlen);

  aclk_cfg_regs #(.RESET_DIV(RESET_DIV)) u_regs (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .if_en   (if_en),
    .we      (cfg_we),
    .wdata   (wdata),
    .cfg_q   (cfg_q),
    .wr_take (wr_take)
  );

  aclk_cfg_check u_check (
    .cfg      (cfg_q),
    .div_zero (div_zero),
    .len_bad  (len_bad),
    .err      (cfg_err)
  );

  assign ratio    = ratio_of(cfg_q.div, cfg_q.odd);
  assign run      = if_en & ~cfg_err;
  assign div_q    = cfg_q.div;
  assign mck_en_q = cfg_q.mck_en;

  aclk_divider #(.W(RAT_W)) u_div (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .run      (run),
    .ratio    (ratio),
    .mck_en   (cfg_q.mck_en),
    .div_clk  (div_clk),
    .tick     (tick),
    .mclk_out (mclk_out),
    .wrap     (wrap)
  );

endmodule

// File: rtl/aclk_checker.sv
module aclk_checker
  import aclk_pkg::*;
(
  input logic             clk_src,
  input logic             rst_n,
  input logic             if_en,
  input logic             cfg_err,
  input logic             div_clk,
  input logic             tick,
  input logic             mclk_out,
  input logic             mck_en_q,
  input logic [DIV_W-1:0] div_q
);

  AST_TICK_HIGH_CLK: assert property (@(posedge clk_src) disable iff (!rst_n)
    tick |-> (div_clk && !$past(div_clk))); // R9
  AST_RISE_HAS_TICK: assert property (@(posedge clk_src) disable iff (!rst_n)
    $rose(div_clk) |-> tick); // R9
  AST_IDLE_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
    !if_en |=> (!div_clk && !tick)); // R8
  AST_ERR_SUPPRESS: assert property (@(posedge clk_src) disable iff (!rst_n)
    cfg_err |=> !div_clk); // R4
  AST_MCK_FOLLOWS: assert property (@(posedge clk_src) disable iff (!rst_n)
    mclk_out |-> div_clk); // R6
  AST_MCK_GATED: assert property (@(posedge clk_src) disable iff (!rst_n)
    !mck_en_q |-> !mclk_out); // R6
  AST_CFG_FROZEN: assert property (@(posedge clk_src) disable iff (!rst_n)
    if_en |=> ($stable(div_q) && $stable(mck_en_q))); // R7
  AST_ZERO_DIV_ERR: assert property (@(posedge clk_src) disable iff (!rst_n)
    (div_q == '0) |-> cfg_err); // R4

endmodule

bind audio_clk_prescaler aclk_checker u_chk (
  .clk_src  (clk_src),
  .rst_n    (rst_n),
  .if_en    (if_en),
  .cfg_err  (cfg_err),
  .div_clk  (div_clk),
  .tick     (tick),
  .mclk_out (mclk_out),
  .mck_en_q (mck_en_q),
  .div_q    (div_q)
);

// File: tb/audio_clk_prescaler_test.sv
module audio_clk_prescaler_test;

  logic       clk_src = 1'b0;
  logic       rst_n = 1'b0;
  logic       if_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic       cfg_odd = 1'b0;
  logic       cfg_mck_en = 1'b0;
  logic       cfg_chan32 = 1'b0;
  logic [1:0] cfg_dlen = 2'b00;
  logic       div_clk, tick, mclk_out, cfg_err;

  int checks = 0;
  int errors = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk_src = ~clk_src;

  audio_clk_prescaler uut (
    .clk_src(clk_src), .rst_n(rst_n), .if_en(if_en), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_odd(cfg_odd), .cfg_mck_en(cfg_mck_en),
    .cfg_chan32(cfg_chan32), .cfg_dlen(cfg_dlen),
    .div_clk(div_clk), .tick(tick), .mclk_out(mclk_out), .cfg_err(cfg_err)
  );

  task automatic check1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: one expected triple per rising edge, sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk_src);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({div_clk, tick, mclk_out} !== e) begin
          errors++;
          $display("FAIL %s: actual clk/tick/mclk=%b expected=%b",
                   t, {div_clk, tick, mclk_out}, e);
        end
      end
    end
  end

  task automatic write_cfg(input int d, input bit o, input bit m,
                           input bit c32, input bit [1:0] dl);
    @(negedge clk_src);
    cfg_div = 8'(d); cfg_odd = o; cfg_mck_en = m;
    cfg_chan32 = c32; cfg_dlen = dl; cfg_we = 1'b1;
    @(negedge clk_src);
    cfg_we = 1'b0;
  endtask

  // ratio r (0 means the output must stay idle), m = master enable expected
  task automatic run_pattern(input int r, input bit m, input int n,
                             input bit mid_write, input string tag);
    @(negedge clk_src);
    if_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      int ph;
      bit hi;
      ph = (r > 0) ? (i % r) : 0;
      hi = (r > 0) && (2 * ph < r);
      exp_q.push_back({hi, (r > 0) && (ph == 0), hi & m});
      tag_q.push_back(tag);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk_src);
      if (mid_write && i == 2) begin
        cfg_div = 8'd9; cfg_odd = ~cfg_odd; cfg_mck_en = ~cfg_mck_en;
        cfg_we = 1'b1;
      end
      if (mid_write && i == 3) cfg_we = 1'b0;
    end
    if_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_q.push_back(3'b000);
      tag_q.push_back({tag, " R8 idle"});
    end
    repeat (3) @(negedge clk_src);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_src);
    check1(div_clk, 1'b0, "R3 div_clk reset");
    check1(tick, 1'b0, "R3 tick reset");
    check1(mclk_out, 1'b0, "R3 mclk reset");
    check1(cfg_err, 1'b0, "R3 err reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk_src);

    // reset ratio 4, master clock gated off
    run_pattern(4, 1'b0, 12, 1'b0, "R3 R6 R9 reset ratio");

    // even ratios
    write_cfg(3, 1'b0, 1'b1, 1'b0, 2'b00);
    check1(cfg_err, 1'b0, "R1 err div3");
    run_pattern(6, 1'b1, 14, 1'b0, "R1 R6 ratio6");
    write_cfg(1, 1'b0, 1'b1, 1'b0, 2'b00);
    run_pattern(2, 1'b1, 8, 1'b0, "R1 ratio2");

    // odd ratios, plus a write while enabled that must be ignored
    write_cfg(3, 1'b1, 1'b1, 1'b0, 2'b00);
    run_pattern(7, 1'b1, 16, 1'b1, "R2 R7 ratio7 midwrite");
    run_pattern(7, 1'b1, 9, 1'b0, "R7 ratio7 kept");
    write_cfg(1, 1'b1, 1'b0, 1'b0, 2'b00);
    run_pattern(3, 1'b0, 9, 1'b0, "R2 R6 ratio3");
    write_cfg(255, 1'b1, 1'b1, 1'b0, 2'b00);
    run_pattern(511, 1'b1, 1030, 1'b0, "R2 ratio511");

    // zero divider
    write_cfg(0, 1'b0, 1'b1, 1'b0, 2'b00);
    check1(cfg_err, 1'b1, "R4 err div0");
    run_pattern(0, 1'b1, 6, 1'b0, "R4 suppressed");

    // length pairings
    write_cfg(2, 1'b0, 1'b1, 1'b0, 2'b01);
    check1(cfg_err, 1'b1, "R5 24 in 16");
    run_pattern(0, 1'b1, 5, 1'b0, "R5 suppressed");
    write_cfg(2, 1'b0, 1'b1, 1'b0, 2'b10);
    check1(cfg_err, 1'b1, "R5 32 in 16");
    write_cfg(2, 1'b0, 1'b1, 1'b1, 2'b11);
    check1(cfg_err, 1'b1, "R5 reserved");
    write_cfg(2, 1'b0, 1'b1, 1'b1, 2'b01);
    check1(cfg_err, 1'b0, "R5 24 in 32");
    write_cfg(2, 1'b1, 1'b1, 1'b1, 2'b10);
    check1(cfg_err, 1'b0, "R5 32 in 32");
    run_pattern(5, 1'b1, 10, 1'b0, "R5 R2 ratio5 valid");

    repeat (3) @(negedge clk_src);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule